// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter Slice

This block is a small synchronous up-counter slice whose state bits all change together on the rising clock edge. At each edge it can be cleared to zero, preset from a parallel data input, advanced by one, or left unchanged. Which of these happens depends only on the control levels sampled at that edge, and the priority runs clear, then load, then count, then hold. The count wraps from all ones back to zero.

Counting needs two enables, and both must be high. One of them, the "trickle" enable, also gates the combinational carry output. The carry is high when that enable is high and the count is all ones. Connecting one slice's carry to the next slice's trickle enable, with the other enable shared, builds a wider synchronous counter without extra gating. A build-time parameter selects the clear behaviour. The clear can act at once, with no clock. It can instead act at the next edge, and then an external decode of a chosen terminal count fed into the clear shortens the counting cycle.

Top module: `ctr_slice`

## Requirements
- R1: With clr_n, load_n, en_p and en_t all high, each rising edge sets q to q+1 modulo 2^WIDTH, so all ones is followed by zero.
- R2: With clr_n and load_n high and either en_p or en_t low, q keeps its value across the edge.
- R3: With clr_n high and load_n low, the next rising edge copies d into q, whatever the levels of en_p and en_t.
- R4: With ASYNC_CLR=0, a low clr_n leaves q unchanged until the next rising edge and sets q to zero at that edge, whatever the levels of load_n, en_p and en_t.
- R5: With ASYNC_CLR=1, a low clr_n forces q to zero without waiting for a clock edge. After clr_n returns high between edges, the slice counts normally from zero at the next edge.
- R6: At an edge, clear takes priority over load, and load takes priority over counting.
- R7: carry is high exactly when en_t is high and q is all ones. It follows en_t within the same cycle, and en_p has no effect on it.
- R8: Two slices, where the low slice's carry drives the high slice's en_t and en_p is shared, count through all 2^(2*WIDTH) values in order and wrap to zero. The high slice's carry is high only at the all-ones count.
- R9: The sequence "clear, preset 12, count 13, 14, 15, 0, 1, 2, then hold while an enable is low" is reproduced on one 4-bit slice.
- R10: With ASYNC_CLR=0 and clr_n driven low by an external decode of q==9, a slice whose enables are held high counts 0 through 9 repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clr_n | input | 1 | Active-low clear; synchronous or asynchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Count enable that does not affect carry |
| en_t | input | 1 | Count enable that also gates carry |
| d | input | WIDTH | Preset data |
| q | output | WIDTH | Registered count |
| carry | output | 1 | High when en_t is high and q is all ones (combinational) |

## Verification
The bench uses WIDTH=4 throughout. It builds a synchronous-clear pair chained into an 8-bit counter, a synchronous-clear slice with its clear driven by a decode of nine, and a separate ASYNC_CLR=1 slice. The 4-bit width keeps the chained pair at 256 states, so one full wrap is swept exhaustively, with the expected count and both carries computed arithmetically from the loop index. The asynchronous instance lets the bench observe a clear that lands between edges and the restart after release. The decoded instance shows the shortened cycle that only the synchronous clear gives.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;
endpackage

// File: rtl/ctr_op_sel.sv
module ctr_op_sel
  import ctr_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output ctr_op_e op
);
  // Edge-time priority: clear, load, count, hold (R6)
  always_comb begin
    if (!clr_n)            op = OP_CLEAR;
    else if (!load_n)      op = OP_LOAD;
    else if (en_p && en_t) op = OP_COUNT;
    else                   op = OP_HOLD;
  end
endmodule

// File: rtl/ctr_next.sv
module ctr_next
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = d;
      OP_COUNT: nxt = cur + ONE;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             en_t,
  output logic             carry
);
  // Terminal-count decode gated by the trickle enable (R7)
  assign carry = en_t & (&cur);
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import ctr_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  ctr_op_e          op;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  ctr_op_sel u_sel (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  ctr_next #(.WIDTH(WIDTH)) u_next (
    .op  (op),
    .cur (cnt_q),
    .d   (d),
    .nxt (cnt_nxt)
  );

  ctr_carry #(.WIDTH(WIDTH)) u_carry (
    .cur  (cnt_q),
    .en_t (en_t),
    .carry(carry)
  );

  generate
    if (ASYNC_CLR) begin : g_async_clr
      // Clear acts immediately; the flop restarts from zero once released (R5)
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
      end
    end else begin : g_sync_clr
      // Clear is one more edge-sampled operation (R4)
      always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
      end
    end
  endgenerate

  assign q = cnt_q;
endmodule

// File: rtl/ctr_slice_chk.sv
module ctr_slice_chk #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b0
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] d,
  input logic [WIDTH-1:0] q,
  input logic             carry
);
  // Armed after clear has been seen at two edges, so q is known
  logic [1:0] arm = 2'b00;
  always_ff @(posedge clk) arm <= {arm[0], arm[0] | ~clr_n};
  logic armed;
  assign armed = (arm == 2'b11);

  a_r1_count: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    (load_n && en_p && en_t) |=> (q == WIDTH'($past(q) + 1'b1)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  a_r3_load: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    (!load_n) |=> (q == $past(d)));

  a_r7_carry_gated: assert property (@(posedge clk) disable iff (!armed)
    (!en_t) |-> (!carry));

  a_r7_carry_wrap: assert property (@(posedge clk) disable iff (!armed || !clr_n)
    (carry && en_p && load_n) |=> (q == '0));

  generate
    if (ASYNC_CLR) begin : g_async
      a_r5_async_zero: assert property (@(posedge clk) disable iff (!armed)
        (!clr_n) |-> (q == '0));
    end else begin : g_sync
      a_r4_sync_zero: assert property (@(posedge clk) disable iff (!armed)
        (!clr_n) |=> (q == '0));
    end
  endgenerate
endmodule

bind ctr_slice ctr_slice_chk #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk   (clk),
  .clr_n (clr_n),
  .load_n(load_n),
  .en_p  (en_p),
  .en_t  (en_t),
  .d     (d),
  .q     (q),
  .carry (carry)
);

// File: tb/tb_ctr_slice.sv
module tb_ctr_slice;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Chained pair, synchronous clear
  logic       clr_n = 1'b0, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [7:0] d8 = '0;
  logic [3:0] ql, qh;
  logic       c_lo, c_hi;
  logic [7:0] q8;
  assign q8 = {qh, ql};

  ctr_slice #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .d(d8[3:0]), .q(ql), .carry(c_lo));

  ctr_slice #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(c_lo),
    .d(d8[7:4]), .q(qh), .carry(c_hi));

  // Modulo-10 slice: clear fed from a decode of nine
  logic [3:0] mq;
  logic       mc;
  logic       m_clr_n;
  assign m_clr_n = clr_n & (mq != 4'd9);

  ctr_slice #(.WIDTH(4), .ASYNC_CLR(1'b0)) dut_mod (
    .clk(clk), .clr_n(m_clr_n), .load_n(1'b1), .en_p(1'b1), .en_t(1'b1),
    .d(4'd0), .q(mq), .carry(mc));

  // Asynchronous-clear slice
  logic       a_clr_n = 1'b0, a_load_n = 1'b1, a_en = 1'b0;
  logic [3:0] a_d = '0;
  logic [3:0] aq;
  logic       ac;

  ctr_slice #(.WIDTH(4), .ASYNC_CLR(1'b1)) dut_async (
    .clk(clk), .clr_n(a_clr_n), .load_n(a_load_n), .en_p(a_en), .en_t(a_en),
    .d(a_d), .q(aq), .carry(ac));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // Reset state through clear
    repeat (3) tick();
    chk("R4 reset zero", q8, 0);
    chk("R5 async reset zero", aq, 0);
    clr_n = 1'b1;
    a_clr_n = 1'b1;

    // R9 reference sequence on the low slice
    d8 = 8'h0C; load_n = 1'b0;
    tick();
    load_n = 1'b0;
    chk("R9 preset 12", ql, 12);
    load_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R9 count step", ql, (12 + k) % 16);
    end
    chk("R1 high slice took carry", qh, 1);
    en_p = 1'b0;
    repeat (3) begin
      tick();
      chk("R9 inhibit hold", ql, 2);
    end

    // R2 hold with each enable low
    en_p = 1'b1; en_t = 1'b0;
    tick(); chk("R2 hold en_t low", q8, 8'h12);
    en_p = 1'b0; en_t = 1'b1;
    tick(); chk("R2 hold en_p low", q8, 8'h12);

    // R3 load regardless of enables
    en_p = 1'b0; en_t = 1'b0; d8 = 8'hA5; load_n = 1'b0;
    tick(); chk("R3 load enables low", q8, 8'hA5);
    en_p = 1'b1; en_t = 1'b1; d8 = 8'h3C;
    tick(); chk("R3 load enables high", q8, 8'h3C);
    d8 = 8'h0F; en_p = 1'b0; en_t = 1'b1;
    tick(); load_n = 1'b1;

    // R7 carry
    chk("R7 carry with en_t at 15", c_lo, 1);
    en_p = 1'b1; #1; chk("R7 en_p no effect", c_lo, 1);
    en_p = 1'b0;
    en_t = 1'b0; #1; chk("R7 carry follows en_t", c_lo, 0);
    en_t = 1'b1; #1; chk("R7 carry back", c_lo, 1);
    d8 = 8'h0E; load_n = 1'b0;
    tick(); load_n = 1'b1;
    chk("R7 no carry at 14", c_lo, 0);

    // R6 clear over load; R4 clear waits for the edge
    d8 = 8'h05; load_n = 1'b0;
    tick();
    chk("R3 load 5", q8, 5);
    clr_n = 1'b0; load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; d8 = 8'h77;
    #2; chk("R4 unchanged before edge", q8, 5);
    tick(); chk("R6 clear beats load", q8, 0);
    clr_n = 1'b1;
    tick(); chk("R6 load beats count", q8, 8'h77);
    load_n = 1'b1;
    tick(); chk("R1 count after load", q8, 8'h78);

    // R8 full cascade sweep
    clr_n = 1'b0;
    tick();
    clr_n = 1'b1; en_p = 1'b1; en_t = 1'b1;
    for (int i = 0; i < 256; i++) begin
      chk("R8 cascade count", q8, i);
      chk("R8 high carry", c_hi, (i == 255) ? 1 : 0);
      chk("R7 low carry", c_lo, ((i % 16) == 15) ? 1 : 0);
      tick();
    end
    chk("R1 wrap to zero", q8, 0);
    en_p = 1'b0;

    // R10 modulo-10 truncation
    clr_n = 1'b0;
    tick();
    clr_n = 1'b1;
    chk("R10 start zero", mq, 0);
    for (int k = 1; k <= 25; k++) begin
      tick();
      chk("R10 modulo ten", mq, k % 10);
    end

    // R5 asynchronous clear
    a_d = 4'd9; a_load_n = 1'b0;
    tick();
    a_load_n = 1'b1;
    chk("R5 async slice loaded", aq, 9);
    #2; a_clr_n = 1'b0;
    #1; chk("R5 zero without edge", aq, 0);
    a_en = 1'b1;
    tick(); chk("R5 held zero at edge", aq, 0);
    #2; a_clr_n = 1'b1;
    #1; chk("R5 still zero after release", aq, 0);
    tick(); chk("R5 resumes from zero", aq, 1);
    tick(); chk("R5 counts on", aq, 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule